// File: doc/BRIEF.md
# Output Short-Circuit Retry Controller

This block supervises the output stages of a multi-channel headphone amplifier against shorts at the amplifier pins. Each channel has its own copy of a small state machine. The state machine watches a digital short indication from an analog comparator. It only acts on that indication while the stage is powered and an audio signal is present. On each valid indication it cuts power to the stage, waits a fixed number of timebase ticks, powers the stage back on and checks again.

If the stage keeps shorting on consecutive retries, the channel latches a fault. The latched fault raises a status flag, raises a high-impedance request for the output pins and keeps the stage off. Reading the flag does not release the fault. Only a software clear strobe for that channel releases it. If a channel stays powered for a full observation window with no valid indication, its strike count returns to zero.

A shared tick input sets the timebase for both the retry wait and the observation window. With a 1 kHz tick and the default parameter, both intervals are 40 ms. A global shutdown input and a per-channel enable hold a channel idle. While a channel is held idle, its short indication is ignored. A channel that has already latched a fault keeps that fault while it is disabled.

Top module: `scp_retry_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `stage_on_o`, `hiz_req_o` and `short_flag_o` are all zero.
- R2: A channel that is enabled, not in shutdown and not faulted drives its `stage_on_o` bit high one clock after it becomes active.
- R3: When `short_det_i` and `sig_present_i` are both high in a cycle in which the stage is on, the stage is off from the next cycle. It stays off for exactly WAIT_TICKS tick pulses and then turns back on.
- R4: `short_det_i` is ignored while `sig_present_i` is low for that channel: the stage stays on and no strike is counted.
- R5: After the stage has been on for WAIT_TICKS tick pulses with no valid indication, the strike count returns to zero. Earlier strikes then no longer count towards a fault.
- R6: On the STRIKES-th consecutive valid indication, the channel's `short_flag_o` and `hiz_req_o` bits go high on the next cycle and the stage stays off. Both bits then stay high, whatever the other inputs do, until that channel's `clr_i` bit is pulsed.
- R7: A one-cycle `clr_i` pulse on a faulted channel drops its flag and high-impedance request on the next cycle. The stage powers up one cycle later if the channel is active.
- R8: A `clr_i` pulse during a retry wait returns the channel to idle with a zero strike count. After that, STRIKES-1 further valid indications do not latch a fault.
- R9: While `sw_shutdown_i` is high or the channel's `ch_en_i` bit is low, a channel that is not faulted keeps its stage off from the next cycle on, and its short indication neither counts nor latches a fault.
- R10: Channels are independent. One channel's indications, clears and fault leave another channel's outputs unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse for the wait and window counters |
| sw_shutdown_i | input | 1 | Global shutdown; holds every channel that is not faulted idle |
| ch_en_i | input | NUM_CH | Per-channel enable |
| sig_present_i | input | NUM_CH | Per-channel input-signal-present qualifier |
| short_det_i | input | NUM_CH | Per-channel short comparator indication |
| clr_i | input | NUM_CH | Per-channel software clear strobe |
| stage_on_o | output | NUM_CH | Per-channel output stage power request |
| hiz_req_o | output | NUM_CH | Per-channel high-impedance request for the output pins |
| short_flag_o | output | NUM_CH | Per-channel latched short status flag |

## Verification
Every output comes straight from a channel state register. The effect of an input is therefore visible one clock after the edge that samples it. The one exception is the retry wait, which ends on the edge that takes in the WAIT_TICKS-th tick after entry. The directed part of the bench drives its inputs on falling edges and holds the tick high. It then reads the outputs at the falling edge after the relevant rising edge: one edge after a detection, clear or enable change, and WAIT_TICKS edges after a detection for the stage to come back on. The random part runs a behavioural model of the requirements in step with the design, fed the same inputs. It compares all three outputs of each channel at every falling edge, so every latency is checked to the exact cycle.

// File: rtl/scp_pkg.sv
package scp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FAULT = 2'd3
   } scp_state_e;
endpackage

// File: rtl/scp_tick_timer.sv
module scp_tick_timer #(
   parameter int LIMIT = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic restart_i,
   output logic done_o
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   assign done_o = tick_i && !restart_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart_i)  cnt_q <= '0;
      else if (done_o)     cnt_q <= '0;
      else if (tick_i)     cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/scp_chan_fsm.sv
module scp_chan_fsm
   import scp_pkg::*;
#(
   parameter int WAIT_TICKS = 40,
   parameter int STRIKES    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic active_i,
   input  logic det_i,
   input  logic clr_i,
   output logic stage_on_o,
   output logic fault_o
);
   localparam int SW = $clog2(STRIKES + 1);
   localparam logic [SW-1:0] LAST_STRIKE = SW'(STRIKES - 1);

   scp_state_e    state_q, state_d;
   logic [SW-1:0] strikes_q, strikes_d;
   logic          restart, done;

   scp_tick_timer #(.LIMIT(WAIT_TICKS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .restart_i (restart),
      .done_o    (done)
   );

   always_comb begin
      state_d   = state_q;
      strikes_d = strikes_q;
      restart   = 1'b0;
      if (clr_i) begin
         state_d   = ST_IDLE;
         strikes_d = '0;
         restart   = 1'b1;
      end else if (state_q == ST_FAULT) begin
         state_d = ST_FAULT;
      end else if (!active_i) begin
         state_d   = ST_IDLE;
         strikes_d = '0;
         restart   = 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               state_d = ST_ARMED;
               restart = 1'b1;
            end
            ST_ARMED: begin
               if (det_i) begin
                  restart   = 1'b1;
                  strikes_d = strikes_q + 1'b1;
                  state_d   = (strikes_q == LAST_STRIKE) ? ST_FAULT : ST_WAIT;
               end else if (done) begin
                  strikes_d = '0;
               end
            end
            ST_WAIT: begin
               if (done) state_d = ST_ARMED;
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         strikes_q <= '0;
      end else begin
         state_q   <= state_d;
         strikes_q <= strikes_d;
      end
   end

   assign stage_on_o = (state_q == ST_ARMED);
   assign fault_o    = (state_q == ST_FAULT);
endmodule

// File: rtl/scp_retry_ctrl.sv
module scp_retry_ctrl #(
   parameter int NUM_CH     = 2,
   parameter int WAIT_TICKS = 40,
   parameter int STRIKES    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              sw_shutdown_i,
   input  logic [NUM_CH-1:0] ch_en_i,
   input  logic [NUM_CH-1:0] sig_present_i,
   input  logic [NUM_CH-1:0] short_det_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] stage_on_o,
   output logic [NUM_CH-1:0] hiz_req_o,
   output logic [NUM_CH-1:0] short_flag_o
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("scp_retry_ctrl: NUM_CH must be at least 1");
   end
   if (WAIT_TICKS < 2) begin : g_bad_wait
      $error("scp_retry_ctrl: WAIT_TICKS must be at least 2");
   end
   if (STRIKES < 1) begin : g_bad_strikes
      $error("scp_retry_ctrl: STRIKES must be at least 1");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic fault;
      scp_chan_fsm #(
         .WAIT_TICKS (WAIT_TICKS),
         .STRIKES    (STRIKES)
      ) u_fsm (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick_i     (tick_i),
         .active_i   (ch_en_i[c] && !sw_shutdown_i),
         .det_i      (short_det_i[c] && sig_present_i[c]),
         .clr_i      (clr_i[c]),
         .stage_on_o (stage_on_o[c]),
         .fault_o    (fault)
      );
      assign hiz_req_o[c]    = fault;
      assign short_flag_o[c] = fault;
   end
endmodule

// File: rtl/scp_retry_ctrl_chk.sv
module scp_retry_ctrl_chk #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_shutdown_i,
   input logic [NUM_CH-1:0] ch_en_i,
   input logic [NUM_CH-1:0] sig_present_i,
   input logic [NUM_CH-1:0] short_det_i,
   input logic [NUM_CH-1:0] clr_i,
   input logic [NUM_CH-1:0] stage_on_o,
   input logic [NUM_CH-1:0] short_flag_o
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R9: an inactive channel has its stage off on the next cycle
      a_r9_inactive_off: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_en_i[i] || sw_shutdown_i) |=> !stage_on_o[i]);
      // R6: the flag holds until a clear arrives
      a_r6_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (short_flag_o[i] && !clr_i[i]) |=> short_flag_o[i]);
      // R6: the flag only rises right after a qualified detection on a powered stage
      a_r6_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(short_flag_o[i]) |-> $past(stage_on_o[i] && short_det_i[i] && sig_present_i[i]));
      // R7: a clear drops the flag and leaves the stage off for one cycle
      a_r7_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i[i] |=> (!short_flag_o[i] && !stage_on_o[i]));
      // R3: a qualified detection on a powered stage cuts power next cycle
      a_r3_detect_cuts: assert property (@(posedge clk) disable iff (!rst_n)
         (stage_on_o[i] && short_det_i[i] && sig_present_i[i]) |=> !stage_on_o[i]);
   end
endmodule

bind scp_retry_ctrl scp_retry_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sw_shutdown_i (sw_shutdown_i),
   .ch_en_i       (ch_en_i),
   .sig_present_i (sig_present_i),
   .short_det_i   (short_det_i),
   .clr_i         (clr_i),
   .stage_on_o    (stage_on_o),
   .short_flag_o  (short_flag_o)
);

// File: tb/scp_retry_ctrl_bench.sv
module scp_retry_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 2;
   localparam int W   = 4;
   localparam int S   = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           tick = 1'b1;
   logic           sd = 1'b0;
   logic [NCH-1:0] en = '0, sig = '1, det = '0, clr = '0;
   logic [NCH-1:0] stage_on, hiz, flag;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scp_retry_ctrl #(.NUM_CH(NCH), .WAIT_TICKS(W), .STRIKES(S)) u_scp_retry_ctrl (
      .clk (clk), .rst_n (rst_n), .tick_i (tick), .sw_shutdown_i (sd),
      .ch_en_i (en), .sig_present_i (sig), .short_det_i (det), .clr_i (clr),
      .stage_on_o (stage_on), .hiz_req_o (hiz), .short_flag_o (flag)
   );

   // behavioural model: 0 idle, 1 armed, 2 waiting, 3 faulted
   int m_st [NCH];
   int m_cnt[NCH];
   int m_tmr[NCH];

   function automatic int exp_out(int st);
      return {29'd0, st == 3, st == 3, st == 1};
   endfunction

   always @(posedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (!rst_n) begin
            m_st[c] = 0; m_cnt[c] = 0; m_tmr[c] = 0;
         end else if (clr[c]) begin
            m_st[c] = 0; m_cnt[c] = 0; m_tmr[c] = 0;
         end else if (m_st[c] == 3) begin
            m_st[c] = 3;
         end else if (!en[c] || sd) begin
            m_st[c] = 0; m_cnt[c] = 0; m_tmr[c] = 0;
         end else if (m_st[c] == 0) begin
            m_st[c] = 1; m_tmr[c] = 0;
         end else if (m_st[c] == 1) begin
            if (det[c] && sig[c]) begin
               m_cnt[c]++; m_tmr[c] = 0;
               m_st[c] = (m_cnt[c] == S) ? 3 : 2;
            end else if (tick) begin
               if (m_tmr[c] == W-1) begin m_tmr[c] = 0; m_cnt[c] = 0; end
               else m_tmr[c]++;
            end
         end else if (tick) begin
            if (m_tmr[c] == W-1) begin m_st[c] = 1; m_tmr[c] = 0; end
            else m_tmr[c]++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_det(input int c);
      det[c] = 1'b1;
      @(negedge clk);
      det[c] = 1'b0;
   endtask

   task automatic pulse_clr(input int c);
      clr[c] = 1'b1;
      @(negedge clk);
      clr[c] = 1'b0;
   endtask

   // strike on channel 0 that does not fault; returns once the stage is back on
   task automatic strike_retry(input string req);
      pulse_det(0);
      chk(stage_on[0] == 1'b0, req, stage_on[0], 0);
      step(W-1);
      chk(stage_on[0] == 1'b0, req, stage_on[0], 0);
      step(1);
      chk(stage_on[0] == 1'b1, req, stage_on[0], 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20250611));
      step(3);
      // R1 reset state
      chk({stage_on, hiz, flag} == '0, "R1", {stage_on, hiz, flag}, 0);
      rst_n = 1'b1;
      step(1);
      chk({stage_on, hiz, flag} == '0, "R1", {stage_on, hiz, flag}, 0);
      // R2 enable powers the stage one clock later
      en = '1;
      step(1);
      chk(stage_on == 2'b11, "R2", stage_on, 3);
      // R4 detection without signal is ignored
      sig[0] = 1'b0;
      pulse_det(0);
      chk(stage_on[0] == 1'b1, "R4", stage_on[0], 1);
      sig[0] = 1'b1;
      // R3 retry timing, then R6 fault on the third strike
      strike_retry("R3");
      strike_retry("R3");
      pulse_det(0);
      chk(flag[0] == 1'b1 && hiz[0] == 1'b1 && stage_on[0] == 1'b0, "R6",
          {flag[0], hiz[0], stage_on[0]}, 6);
      // R10 other channel unaffected
      chk(stage_on[1] == 1'b1 && flag[1] == 1'b0, "R10", {stage_on[1], flag[1]}, 2);
      step(20);
      chk(flag[0] == 1'b1, "R6", flag[0], 1);
      en[0] = 1'b0;
      step(2);
      chk(flag[0] == 1'b1 && hiz[0] == 1'b1, "R6", {flag[0], hiz[0]}, 3);
      en[0] = 1'b1;
      // R7 clear releases the fault
      pulse_clr(0);
      chk(flag[0] == 1'b0 && hiz[0] == 1'b0 && stage_on[0] == 1'b0, "R7",
          {flag[0], hiz[0], stage_on[0]}, 0);
      step(1);
      chk(stage_on[0] == 1'b1, "R7", stage_on[0], 1);
      // R5 window expiry forgets earlier strikes
      strike_retry("R5");
      step(W + 2);
      strike_retry("R5");
      pulse_det(0);
      chk(flag[0] == 1'b0, "R5", flag[0], 0);
      step(W);
      chk(stage_on[0] == 1'b1, "R5", stage_on[0], 1);
      pulse_clr(0);
      step(1);
      // R8 clear during a wait resets the strike count
      strike_retry("R8");
      pulse_det(0);
      step(1);
      pulse_clr(0);
      chk(stage_on[0] == 1'b0 && flag[0] == 1'b0, "R8", {stage_on[0], flag[0]}, 0);
      step(1);
      chk(stage_on[0] == 1'b1, "R8", stage_on[0], 1);
      strike_retry("R8");
      pulse_det(0);
      chk(flag[0] == 1'b0, "R8", flag[0], 0);
      step(W);
      // R9 shutdown holds idle and ignores detections
      sd = 1'b1;
      step(1);
      chk(stage_on == 2'b00, "R9", stage_on, 0);
      det = '1;
      step(6);
      det = '0;
      chk(flag == 2'b00 && stage_on == 2'b00, "R9", {flag, stage_on}, 0);
      sd = 1'b0;
      step(1);
      chk(stage_on == 2'b11, "R9", stage_on, 3);
      // random phase against the model (R2..R10)
      for (int n = 0; n < 4000; n++) begin
         for (int c = 0; c < NCH; c++) begin
            int e = exp_out(m_st[c]);
            int a = {29'd0, flag[c], hiz[c], stage_on[c]};
            chk(a == e, "R3/R5/R6/R9 model", a, e);
         end
         tick = ($urandom % 2) == 0;
         sd   = ($urandom % 40) == 0;
         for (int c = 0; c < NCH; c++) begin
            en[c]  = ($urandom % 12) != 0;
            sig[c] = ($urandom % 5) != 0;
            det[c] = ($urandom % 6) == 0;
            clr[c] = ($urandom % 60) == 0;
         end
         step(1);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule